// File: doc/BRIEF.md
# Word Read Bus Cycle Controller

This block runs one word-wide read cycle at a time on a processor bus whose slaves end each cycle with a handshake. A client presents an address, a flag that marks the access as either an instruction fetch or a data access, and the current privilege level. The controller then drives the address strobe, the read/write line, the word-select line and a three-bit function code. Each clock of the block stands for one half-cycle of the processor clock.

A cycle has three phases. The announce phase puts the new address on the bus. If the slave has not terminated the cycle by the end of that phase, the controller adds wait steps of a fixed length and keeps the bus unchanged until it sees any of three termination inputs: acknowledge, bus error or slow-peripheral. A completion phase follows. It keeps the same address and raises word select. On the final edge of the completion phase the read word is captured and returned with a one-clock done pulse, together with the bus-error level seen on that edge.

A build parameter can make termination implicit. In that mode the termination inputs are ignored and no wait step is ever added.

Top module: `bus_read_cycle_ctrl`

## Requirements
- R1: After reset, and whenever no cycle is running, `req_ready` is 1 and `bus_strobe`, `bus_word`, `done` and `bus_fc` are all 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both 1. While a cycle runs, `req_ready` is 0, and a request made then has no effect: the bus address stays at the address of the running cycle and only one done pulse appears.
- R3: The clock after a request is taken starts the announce phase. The announce phase lasts ANNOUNCE_HC clocks (default 4). During it `bus_strobe` is 1, `bus_word` is 0, `bus_rw` is 1 (read) and `bus_addr` equals the requested address.
- R4: While `bus_strobe` is 1, `bus_fc` is {privilege, fetch, not fetch}. This gives 3'b001 for user data, 3'b010 for user fetch, 3'b101 for privileged data and 3'b110 for privileged fetch.
- R5: The termination inputs are sampled on the last edge of the announce phase and on the last edge of each wait step. If none is high there, a wait step of WAIT_HC clocks (default 2) is added, with the bus held as in the announce phase.
- R6: Any one of `bus_ack`, `bus_err` or `bus_slow` being high at a sample point ends the waiting, and the completion phase begins.
- R7: The completion phase lasts COMPLETE_HC clocks (default 2). During it `bus_strobe` and `bus_word` are 1 and `bus_addr` is unchanged.
- R8: `bus_rdata` is captured on the last edge of the completion phase. On the clock after that edge, `done` is 1 for exactly one clock, `done_data` holds the captured word, and `bus_strobe` is 0.
- R9: `done_err` equals the level of `bus_err` on the edge that captured the data.
- R10: With IMPLICIT_TERM = 1, no wait step is ever added. With the default phase lengths, done follows the accepting edge by exactly 6 clocks whatever the termination inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request a read cycle |
| req_addr | input | ADDR_W | Address to read |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_priv | input | 1 | 1 = privileged, 0 = user |
| req_ready | output | 1 | Controller idle, request can be taken |
| bus_addr | output | ADDR_W | Bus address |
| bus_strobe | output | 1 | Address strobe, high through the whole cycle |
| bus_rw | output | 1 | Read/write, 1 = read |
| bus_word | output | 1 | Word transfer select, high in the completion phase |
| bus_fc | output | 3 | Function code |
| bus_ack | input | 1 | Slave acknowledge termination |
| bus_err | input | 1 | Bus error termination |
| bus_slow | input | 1 | Slow-peripheral termination |
| bus_rdata | input | DATA_W | Read data from the slave |
| done | output | 1 | One-clock pulse, cycle complete |
| done_data | output | DATA_W | Captured read word |
| done_err | output | 1 | Bus error level at capture |

## Verification
For each of the three termination inputs, the bench raises that input after a delay that is swept from zero to nine clocks. It then compares the observed done latency, the number of announce-plus-wait clocks and the number of completion clocks against values worked out from the sample points. This separates an off-by-one in the announce length, an error in the wait-step length and a termination input that is not heard. The privilege and fetch flags are varied across the cases to cover all four function codes. A junk request is held asserted during every cycle to show that a busy controller ignores it. The implicit-termination build is run with all termination inputs low, and it must still finish in the fixed time.

// File: rtl/brc_pkg.sv
// Shared types for the word read bus cycle controller.
// Assumes a three-bit function code of {privilege, fetch, not fetch}.
package brc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_ANNOUNCE = 2'd1,
        PH_WAIT     = 2'd2,
        PH_COMPLETE = 2'd3
    } phase_t;

    // Build the function code from the privilege level and the space flag.
    function automatic logic [2:0] fc_code(input logic priv, input logic fetch);
        return {priv, fetch, ~fetch};
    endfunction
endpackage

// File: rtl/brc_phase_timer.sv
// Down counter that measures the length of one phase.
// A load sets the count, and the count then falls by one per clock to zero.
// expired is high on the last clock of the loaded length.
module brc_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Load a new length, or count down to zero and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/brc_sequencer.sv
// Phase sequencer: idle, announce, wait steps, completion.
// Assumes the timer expires on the last clock of each phase. Termination is
// sampled only on that clock, and only in the announce or wait phase.
module brc_sequencer
    import brc_pkg::*;
#(
    parameter int ANNOUNCE_HC   = 4,
    parameter int WAIT_HC       = 2,
    parameter int COMPLETE_HC   = 2,
    parameter bit IMPLICIT_TERM = 1'b0,
    parameter int CNT_W         = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             terminate,
    input  logic             expired,
    output phase_t           phase,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             finish
);
    localparam logic [CNT_W-1:0] ANN_LEN  = CNT_W'(ANNOUNCE_HC - 1);
    localparam logic [CNT_W-1:0] WAIT_LEN = CNT_W'(WAIT_HC - 1);
    localparam logic [CNT_W-1:0] COMP_LEN = CNT_W'(COMPLETE_HC - 1);

    phase_t phase_nx;
    logic   term_ok;

    generate
        if (IMPLICIT_TERM) begin : g_implicit
            // The slave is taken to end every cycle at once.
            assign term_ok = 1'b1;
        end else begin : g_handshake
            // The slave ends the cycle through the termination inputs.
            assign term_ok = terminate;
        end
    endgenerate

    // Choose the next phase and the timer reload.
    always_comb begin
        phase_nx = phase;
        load     = 1'b0;
        load_val = '0;
        finish   = 1'b0;
        case (phase)
            PH_IDLE: begin
                if (start) begin
                    phase_nx = PH_ANNOUNCE;
                    load     = 1'b1;
                    load_val = ANN_LEN;
                end
            end
            PH_ANNOUNCE, PH_WAIT: begin
                if (expired) begin
                    load = 1'b1;
                    if (term_ok) begin
                        phase_nx = PH_COMPLETE;
                        load_val = COMP_LEN;
                    end else begin
                        phase_nx = PH_WAIT;
                        load_val = WAIT_LEN;
                    end
                end
            end
            PH_COMPLETE: begin
                if (expired) begin
                    phase_nx = PH_IDLE;
                    finish   = 1'b1;
                end
            end
            default: phase_nx = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= PH_IDLE;
        else
            phase <= phase_nx;
    end
endmodule

// File: rtl/brc_capture.sv
// Holds the request fields for the length of the cycle, and captures the read
// word and the bus-error level when the cycle finishes.
// Assumes start and finish never arrive together.
module brc_capture #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [2:0]        fc_in,
    input  logic              finish,
    input  logic [DATA_W-1:0] rdata,
    input  logic              err_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [2:0]        fc_q,
    output logic              done,
    output logic [DATA_W-1:0] data_q,
    output logic              err_q
);
    // Hold the address and function code of the request that was taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            fc_q   <= '0;
        end else if (start) begin
            addr_q <= addr_in;
            fc_q   <= fc_in;
        end
    end

    // Capture the result and raise done for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            data_q <= '0;
            err_q  <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                data_q <= rdata;
                err_q  <= err_in;
            end
        end
    end
endmodule

// File: rtl/bus_read_cycle_ctrl.sv
// Word read bus cycle controller, top level.
// Runs one read cycle per request: announce, optional wait steps, completion.
// One clock is one processor half-cycle. Phase lengths are parameters.
module bus_read_cycle_ctrl
    import brc_pkg::*;
#(
    parameter int ADDR_W        = 24,
    parameter int DATA_W        = 16,
    parameter int ANNOUNCE_HC   = 4,
    parameter int WAIT_HC       = 2,
    parameter int COMPLETE_HC   = 2,
    parameter bit IMPLICIT_TERM = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_fetch,
    input  logic              req_priv,
    output logic              req_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_strobe,
    output logic              bus_rw,
    output logic              bus_word,
    output logic [2:0]        bus_fc,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic              bus_slow,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic [DATA_W-1:0] done_data,
    output logic              done_err
);
    localparam int MAX_HC = (ANNOUNCE_HC > WAIT_HC)
                          ? ((ANNOUNCE_HC > COMPLETE_HC) ? ANNOUNCE_HC : COMPLETE_HC)
                          : ((WAIT_HC > COMPLETE_HC) ? WAIT_HC : COMPLETE_HC);
    localparam int CNT_W  = (MAX_HC < 2) ? 1 : $clog2(MAX_HC);

    phase_t           phase;
    logic             start;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;
    logic             finish;
    logic [2:0]       fc_q;

    assign req_ready = (phase == PH_IDLE);
    assign start     = req_valid && req_ready;

    brc_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    brc_sequencer #(
        .ANNOUNCE_HC   (ANNOUNCE_HC),
        .WAIT_HC       (WAIT_HC),
        .COMPLETE_HC   (COMPLETE_HC),
        .IMPLICIT_TERM (IMPLICIT_TERM),
        .CNT_W         (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .terminate (bus_ack || bus_err || bus_slow),
        .expired   (expired),
        .phase     (phase),
        .load      (load),
        .load_val  (load_val),
        .finish    (finish)
    );

    brc_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .addr_in (req_addr),
        .fc_in   (fc_code(req_priv, req_fetch)),
        .finish  (finish),
        .rdata   (bus_rdata),
        .err_in  (bus_err),
        .addr_q  (bus_addr),
        .fc_q    (fc_q),
        .done    (done),
        .data_q  (done_data),
        .err_q   (done_err)
    );

    assign bus_strobe = (phase != PH_IDLE);
    assign bus_word   = (phase == PH_COMPLETE);
    assign bus_rw     = 1'b1;
    assign bus_fc     = bus_strobe ? fc_q : 3'b000;
endmodule

// File: rtl/bus_read_cycle_ctrl_chk.sv
// Port-level protocol checker for bus_read_cycle_ctrl, bound to every instance.
module bus_read_cycle_ctrl_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_strobe,
    input logic              bus_rw,
    input logic              bus_word,
    input logic [2:0]        bus_fc,
    input logic              done
);
    // R1: an idle controller drives no strobe and no function code
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_strobe && !bus_word && bus_fc == 3'b000));

    // R2: the address does not move while a cycle runs
    a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(bus_addr));

    // R3: an accepted request opens the announce phase
    a_r3_announce_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (bus_strobe && !bus_word && bus_rw));

    // R4: a running cycle carries exactly one of the data or fetch codes
    a_r4_fc_space: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |-> ($countones(bus_fc[1:0]) == 1));

    // R7: word select comes only inside an active strobe
    a_r7_word_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bus_word |-> bus_strobe);

    // R8: the end of the completion phase brings done, and done lasts one clock
    a_r8_done_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_word) |-> (done && !bus_strobe));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind bus_read_cycle_ctrl bus_read_cycle_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .bus_addr   (bus_addr),
    .bus_strobe (bus_strobe),
    .bus_rw     (bus_rw),
    .bus_word   (bus_word),
    .bus_fc     (bus_fc),
    .done       (done)
);

// File: tb/bus_read_cycle_ctrl_tb.sv
// Bench: sweeps the termination delay and the termination source on the
// handshake build, then runs the implicit-termination build.
module bus_read_cycle_ctrl_tb;
    localparam int AW = 24;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;

    // Handshake build signals
    logic          h_valid = 0, h_fetch = 0, h_priv = 0;
    logic [AW-1:0] h_addr = '0;
    logic          h_ack = 0, h_err = 0, h_slow = 0;
    logic          h_ready, h_strobe, h_rw, h_word, h_done, h_derr;
    logic [AW-1:0] h_baddr;
    logic [2:0]    h_fc;
    logic [DW-1:0] h_ddata, h_rdata;

    // Implicit build signals
    logic          i_valid = 0, i_fetch = 0, i_priv = 0;
    logic [AW-1:0] i_addr = '0;
    logic          i_ready, i_strobe, i_rw, i_word, i_done, i_derr;
    logic [AW-1:0] i_baddr;
    logic [2:0]    i_fc;
    logic [DW-1:0] i_ddata, i_rdata;

    // The slave returns a word computed from the address while word select is high.
    assign h_rdata = h_word ? (h_baddr[DW-1:0] ^ 16'hA5C3) : 16'h0000;
    assign i_rdata = i_word ? (i_baddr[DW-1:0] ^ 16'hA5C3) : 16'h0000;

    bus_read_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(h_valid), .req_addr(h_addr), .req_fetch(h_fetch), .req_priv(h_priv),
        .req_ready(h_ready), .bus_addr(h_baddr), .bus_strobe(h_strobe), .bus_rw(h_rw),
        .bus_word(h_word), .bus_fc(h_fc), .bus_ack(h_ack), .bus_err(h_err),
        .bus_slow(h_slow), .bus_rdata(h_rdata), .done(h_done), .done_data(h_ddata),
        .done_err(h_derr)
    );

    bus_read_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IMPLICIT_TERM(1'b1)) u_dut_imp (
        .clk(clk), .rst_n(rst_n),
        .req_valid(i_valid), .req_addr(i_addr), .req_fetch(i_fetch), .req_priv(i_priv),
        .req_ready(i_ready), .bus_addr(i_baddr), .bus_strobe(i_strobe), .bus_rw(i_rw),
        .bus_word(i_word), .bus_fc(i_fc), .bus_ack(1'b0), .bus_err(1'b0),
        .bus_slow(1'b0), .bus_rdata(i_rdata), .done(i_done), .done_data(i_ddata),
        .done_err(i_derr)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One handshake cycle: the terminator src (0 ack, 1 err, 2 slow) goes high after edge d.
    task automatic run_hs(input int d, input int src, input logic [AW-1:0] a,
                          input logic fe, input logic pv);
        int e, n, ann, wrd, dones;
        bit addr_ok, fc_ok, fin;
        logic [2:0] fc_exp;
        fc_exp  = {pv, fe, ~fe};
        n       = ((d + 2) / 2) * 2;
        if (n < 4) n = 4;
        ann = 0; wrd = 0; dones = 0; addr_ok = 1; fc_ok = 1; fin = 0;
        @(negedge clk);
        check(h_ready == 1'b1, "R2 ready before request", h_ready, 1);
        h_valid = 1; h_addr = a; h_fetch = fe; h_priv = pv;
        @(posedge clk);
        e = 0;
        for (int k = 0; k < 60 && !fin; k++) begin
            @(negedge clk);
            // A junk request is held while busy.
            h_addr = ~a; h_fetch = ~fe;
            if (e >= d) begin
                h_ack = (src == 0); h_err = (src == 1); h_slow = (src == 2);
            end
            if (h_strobe) begin
                if (h_baddr != a) addr_ok = 0;
                if (h_fc != fc_exp) fc_ok = 0;
                if (h_ready) addr_ok = 0;
            end
            if (h_strobe && !h_word) ann++;
            if (h_word) wrd++;
            if (h_done) begin
                dones++;
                fin = 1;
                h_valid = 0;
                check(e == n + 2, "R5 R6 done latency", e, n + 2);
                check(h_ddata == (a[DW-1:0] ^ 16'hA5C3), "R8 captured data", h_ddata, a[DW-1:0] ^ 16'hA5C3);
                check(h_derr == (src == 1), "R9 error level", h_derr, src == 1);
                check(!h_strobe, "R8 strobe dropped with done", h_strobe, 0);
            end
            e++;
        end
        check(fin, "R8 done seen", fin, 1);
        check(ann == n, "R3 R5 announce plus wait clocks", ann, n);
        check(wrd == 2, "R7 completion clocks", wrd, 2);
        check(addr_ok, "R2 R3 address held, junk ignored", addr_ok, 1);
        check(fc_ok, "R4 function code", fc_ok, 1);
        h_ack = 0; h_err = 0; h_slow = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (h_strobe || h_done) dones++;
        end
        check(dones == 1, "R2 single done, no junk cycle", dones, 1);
        check(h_ready && !h_strobe && h_fc == 3'b000, "R1 idle after cycle", {h_ready, h_strobe, h_fc}, 5'b10000);
    endtask

    task automatic run_imp(input logic [AW-1:0] a, input logic fe, input logic pv);
        int e, ann;
        bit fin;
        ann = 0; fin = 0;
        @(negedge clk);
        i_valid = 1; i_addr = a; i_fetch = fe; i_priv = pv;
        @(posedge clk);
        e = 0;
        for (int k = 0; k < 40 && !fin; k++) begin
            @(negedge clk);
            i_valid = 0;
            if (i_strobe && !i_word) ann++;
            if (i_done) begin
                fin = 1;
                check(e == 6, "R10 implicit latency", e, 6);
                check(i_ddata == (a[DW-1:0] ^ 16'hA5C3), "R10 implicit data", i_ddata, a[DW-1:0] ^ 16'hA5C3);
            end
            e++;
        end
        check(fin, "R10 implicit done seen", fin, 1);
        check(ann == 4, "R10 no wait step", ann, 4);
    endtask

    // Watchdog.
    initial begin
        #1000000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(h_ready && !h_strobe && !h_word && !h_done && h_fc == 3'b000,
              "R1 reset state", {h_ready, h_strobe, h_word, h_done}, 4'b1000);
        check(i_ready && !i_strobe && !i_done, "R1 reset state implicit",
              {i_ready, i_strobe, i_done}, 3'b100);
        for (int src = 0; src < 3; src++)
            for (int d = 0; d < 10; d++)
                run_hs(d, src, AW'(24'h01_2340 + src * 4096 + d * 18),
                       logic'(d[0]), logic'(d[1]));
        for (int k = 0; k < 4; k++)
            run_imp(AW'(24'h00_7F00 + k * 6), logic'(k[0]), logic'(k[1]));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule